// File: doc/BRIEF.md
# Operand Address Decoder

This block parses the addressing bytes that follow an opcode: a leading mode/register/operand byte, an optional scaled-index byte and a displacement of zero to four bytes. It accepts one byte per cycle over a valid/ready handshake and follows whichever byte layout the first byte selects. When the last byte arrives it forms the operand address from a snapshot of the eight general registers. Each register is a 32-bit field of one flat input bus.

A mode input picks 16-bit or 32-bit addressing. It is sampled together with the first byte. The result is held on the outputs: the effective address, a register-direct flag with the register number, the middle field of the first byte and the number of bytes consumed. A one-cycle done strobe marks each new result. The parser then returns to wait for the next sequence. Segments, prefixes and opcode decoding are left to neighbouring logic.

Top module: `ea_decoder`

## Requirements
- R1: In the first byte, bits 7:6 are the mode, bits 5:3 are reported on `spareOut`, and bits 2:0 are the operand field. `lenOut` gives the total bytes consumed, which is 1, 2, 3, 5 or 6.
- R2: A mode value of 3 selects a register operand. `regDirect` is 1, `rmReg` is the operand field, `lenOut` is 1, `eaOut` is 0, and no further byte is consumed.
- R3: In 16-bit addressing, mode 0, 1 and 2 carry 0, 1 and 2 displacement bytes. Operand field values 0 to 7 add BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. Register numbers are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6 and DI=7, and only the low 16 bits of each register are used.
- R4: In 16-bit addressing, mode 0 with operand field 6 means a 2-byte displacement alone (`lenOut` 3).
- R5: In 32-bit addressing, mode 0, 1 and 2 carry 0, 1 and 4 displacement bytes. Any operand field other than 4 names the single base register.
- R6: In 32-bit addressing, mode 0 with operand field 5 means a 4-byte displacement alone (`lenOut` 5).
- R7: In 32-bit addressing, operand field 4 brings in a second byte. Its bits 7:6 give the index multiplier: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Bits 5:3 give the index register, where 4 means no index. Bits 2:0 give the base register.
- R8: When that second byte is present with mode 0 and a base field of 5, no base register is added and a 4-byte displacement follows (`lenOut` 6). With mode 1 or 2, base field 5 adds register 5 as usual.
- R9: Displacement bytes are taken least significant first and are sign-extended. Sums wrap modulo 2^16 in 16-bit mode and modulo 2^32 in 32-bit mode; in 16-bit mode the upper 16 bits of `eaOut` are 0.
- R10: `done` is high for exactly the one cycle after the final byte is accepted, and `inReady` is low in that cycle. Outputs change only when `done` rises and hold until the next result. Idle cycles with `inValid` low between bytes are tolerated.
- R11: After reset, `done` is 0, `inReady` is 1, and `eaOut`, `lenOut`, `regDirect`, `rmReg` and `spareOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit; sampled with the first byte |
| inByte | input | 8 | Incoming addressing byte |
| inValid | input | 1 | `inByte` is valid |
| inReady | output | 1 | Block can take a byte this cycle |
| regSnap | input | 256 | Register k in bits 32k+31:32k |
| eaOut | output | 32 | Effective address |
| regDirect | output | 1 | Operand is a register |
| rmReg | output | 3 | Operand field of the first byte |
| spareOut | output | 3 | Bits 5:3 of the first byte |
| lenOut | output | 3 | Bytes consumed by the sequence |
| done | output | 1 | One-cycle result strobe |

## Verification
Every operand field in 16-bit mode is driven once. The bench uses a register snapshot in which every register holds a distinct value, so a wrong base/index pairing shows up as a wrong sum. Displacements with the top bit set separate sign extension from zero extension. One 16-bit sum that passes 0xFFFF checks that the result wraps. Scaled-index bytes are sent with each multiplier, with the no-index code and with base field 5 under both mode 0 and mode 1, which tells the displacement-only exception apart from an ordinary base register. Byte gaps and a byte presented during the done cycle show that acceptance follows the handshake and not a fixed count of cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W     = 32;
  localparam int HALF_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int REG_CNT    = 8;
  localparam int REG_IDX_W  = $clog2(REG_CNT);
  localparam int MAX_DISP   = ADDR_W / BYTE_W;
  localparam int DISP_IDX_W = $clog2(MAX_DISP);
  localparam int CNT_W      = DISP_IDX_W + 1;
  localparam int LEN_W      = 3;

  // fixed register numbers used by the 16-bit table
  localparam logic [REG_IDX_W-1:0] RN_BX = 3'd3;
  localparam logic [REG_IDX_W-1:0] RN_BP = 3'd5;
  localparam logic [REG_IDX_W-1:0] RN_SI = 3'd6;
  localparam logic [REG_IDX_W-1:0] RN_DI = 3'd7;
  localparam logic [REG_IDX_W-1:0] NO_INDEX = 3'd4;

  typedef struct packed {
    logic                  capModrm;
    logic                  capSib;
    logic                  capDisp;
    logic [DISP_IDX_W-1:0] dispIdx;
    logic                  finish;
    logic [LEN_W-1:0]      len;
  } strobe_t;

  typedef struct packed {
    logic         direct;
    logic         hasSib;
    logic [CNT_W-1:0] dispLen;
  } modrm_info_t;

  function automatic modrm_info_t decodeModrm(logic [BYTE_W-1:0] b, logic m32);
    modrm_info_t r;
    logic [1:0] md;
    logic [2:0] rm;
    md = b[7:6];
    rm = b[2:0];
    r.direct  = (md == 2'd3);
    r.hasSib  = m32 && (md != 2'd3) && (rm == 3'd4);
    r.dispLen = '0;
    case (md)
      2'd1: r.dispLen = CNT_W'(1);
      2'd2: r.dispLen = m32 ? CNT_W'(4) : CNT_W'(2);
      2'd0: begin
        if (!m32 && rm == 3'd6) r.dispLen = CNT_W'(2);
        else if (m32 && rm == 3'd5) r.dispLen = CNT_W'(4);
      end
      default: r.dispLen = '0;
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] sibDispLen(logic [1:0] md, logic [BYTE_W-1:0] sib,
                                                  logic [CNT_W-1:0] baseLen);
    if (md == 2'd0 && sib[2:0] == 3'd5) return CNT_W'(4);
    return baseLen;
  endfunction
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  output logic              inReady,
  output logic              done,
  output strobe_t           stb
);
  typedef enum logic [1:0] {ST_MODRM, ST_SIB, ST_DISP, ST_DONE} state_t;

  state_t           state, stateNext;
  logic [CNT_W-1:0] dispLenQ, dispLenD;
  logic [CNT_W-1:0] dispCnt, dispCntD;
  logic [LEN_W-1:0] consumed, consumedD;
  logic [1:0]       modQ, modD;
  logic             accept;
  modrm_info_t      info;
  logic [CNT_W-1:0] sibLen;

  assign inReady = (state != ST_DONE);
  assign done    = (state == ST_DONE);
  assign accept  = inValid && inReady;
  assign info    = decodeModrm(inByte, mode32);
  assign sibLen  = sibDispLen(modQ, inByte, dispLenQ);

  always_comb begin
    stateNext = state;
    dispLenD  = dispLenQ;
    dispCntD  = dispCnt;
    consumedD = consumed;
    modD      = modQ;
    stb       = '0;
    if (accept) consumedD = consumed + LEN_W'(1);
    case (state)
      ST_MODRM: if (accept) begin
        stb.capModrm = 1'b1;
        consumedD    = LEN_W'(1);
        modD         = inByte[7:6];
        dispLenD     = info.dispLen;
        dispCntD     = '0;
        if (info.direct || (!info.hasSib && info.dispLen == '0)) begin
          stb.finish = 1'b1;
          stateNext  = ST_DONE;
        end else if (info.hasSib) begin
          stateNext = ST_SIB;
        end else begin
          stateNext = ST_DISP;
        end
      end
      ST_SIB: if (accept) begin
        stb.capSib = 1'b1;
        dispLenD   = sibLen;
        if (sibLen == '0) begin
          stb.finish = 1'b1;
          stateNext  = ST_DONE;
        end else begin
          stateNext = ST_DISP;
        end
      end
      ST_DISP: if (accept) begin
        stb.capDisp = 1'b1;
        stb.dispIdx = dispCnt[DISP_IDX_W-1:0];
        dispCntD    = dispCnt + CNT_W'(1);
        if (dispCnt + CNT_W'(1) == dispLenQ) begin
          stb.finish = 1'b1;
          stateNext  = ST_DONE;
        end
      end
      default: stateNext = ST_MODRM;
    endcase
    stb.len = consumedD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_MODRM;
      dispLenQ <= '0;
      dispCnt  <= '0;
      consumed <= '0;
      modQ     <= '0;
    end else begin
      state    <= stateNext;
      dispLenQ <= dispLenD;
      dispCnt  <= dispCntD;
      consumed <= consumedD;
      modQ     <= modD;
    end
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
(
  input  logic                      mode32,
  input  logic [BYTE_W-1:0]         modrm,
  input  logic [BYTE_W-1:0]         sib,
  input  logic [ADDR_W-1:0]         dispExt,
  input  logic [REG_CNT*ADDR_W-1:0] regSnap,
  output logic [ADDR_W-1:0]         ea
);
  logic [ADDR_W-1:0] regArr [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_unpack
    assign regArr[g] = regSnap[g*ADDR_W +: ADDR_W];
  end

  logic [1:0]        md;
  logic [2:0]        rm;
  logic [HALF_W-1:0] base16, index16, sum16;
  logic [ADDR_W-1:0] base32, index32, sum32;

  assign md = modrm[7:6];
  assign rm = modrm[2:0];

  always_comb begin
    base16  = '0;
    index16 = '0;
    case (rm)
      3'd0: begin base16 = regArr[RN_BX][HALF_W-1:0]; index16 = regArr[RN_SI][HALF_W-1:0]; end
      3'd1: begin base16 = regArr[RN_BX][HALF_W-1:0]; index16 = regArr[RN_DI][HALF_W-1:0]; end
      3'd2: begin base16 = regArr[RN_BP][HALF_W-1:0]; index16 = regArr[RN_SI][HALF_W-1:0]; end
      3'd3: begin base16 = regArr[RN_BP][HALF_W-1:0]; index16 = regArr[RN_DI][HALF_W-1:0]; end
      3'd4: base16 = regArr[RN_SI][HALF_W-1:0];
      3'd5: base16 = regArr[RN_DI][HALF_W-1:0];
      3'd6: base16 = (md == 2'd0) ? '0 : regArr[RN_BP][HALF_W-1:0];
      default: base16 = regArr[RN_BX][HALF_W-1:0];
    endcase
    sum16 = base16 + index16 + dispExt[HALF_W-1:0];
  end

  always_comb begin
    base32  = '0;
    index32 = '0;
    if (rm == 3'd4) begin
      if (!(md == 2'd0 && sib[2:0] == 3'd5)) base32 = regArr[sib[2:0]];
      if (sib[5:3] != NO_INDEX) index32 = regArr[sib[5:3]] << sib[7:6];
    end else if (!(md == 2'd0 && rm == 3'd5)) begin
      base32 = regArr[rm];
    end
    sum32 = base32 + index32 + dispExt;
  end

  always_comb begin
    if (md == 2'd3)  ea = '0;
    else if (mode32) ea = sum32;
    else             ea = {{(ADDR_W-HALF_W){1'b0}}, sum16};
  end
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode32,
  input  logic [BYTE_W-1:0]         inByte,
  input  logic [REG_CNT*ADDR_W-1:0] regSnap,
  input  strobe_t                   stb,
  output logic [ADDR_W-1:0]         eaOut,
  output logic                      regDirect,
  output logic [2:0]                rmReg,
  output logic [2:0]                spareOut,
  output logic [LEN_W-1:0]          lenOut
);
  logic [BYTE_W-1:0] modrmQ, sibQ, modrmE, sibE;
  logic [ADDR_W-1:0] dispQ, dispE, dispExt, eaCalc;
  logic              modeQ, modeE;
  modrm_info_t       info;
  logic [CNT_W-1:0]  dLen;

  assign modrmE = stb.capModrm ? inByte : modrmQ;
  assign modeE  = stb.capModrm ? mode32 : modeQ;
  assign sibE   = stb.capSib   ? inByte : sibQ;

  always_comb begin
    dispE = stb.capModrm ? '0 : dispQ;
    if (stb.capDisp)
      dispE = dispE | (ADDR_W'(inByte) << (BYTE_W * int'(stb.dispIdx)));
  end

  assign info = decodeModrm(modrmE, modeE);
  assign dLen = info.hasSib ? sibDispLen(modrmE[7:6], sibE, info.dispLen) : info.dispLen;

  always_comb begin
    case (dLen)
      CNT_W'(1): dispExt = {{(ADDR_W-8){dispE[7]}}, dispE[7:0]};
      CNT_W'(2): dispExt = {{(ADDR_W-16){dispE[15]}}, dispE[15:0]};
      CNT_W'(4): dispExt = dispE;
      default:   dispExt = '0;
    endcase
  end

  ea_addr_calc calc_i (
    .mode32 (modeE),
    .modrm  (modrmE),
    .sib    (sibE),
    .dispExt(dispExt),
    .regSnap(regSnap),
    .ea     (eaCalc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modrmQ    <= '0;
      sibQ      <= '0;
      dispQ     <= '0;
      modeQ     <= 1'b0;
      eaOut     <= '0;
      regDirect <= 1'b0;
      rmReg     <= '0;
      spareOut  <= '0;
      lenOut    <= '0;
    end else begin
      modrmQ <= modrmE;
      sibQ   <= sibE;
      dispQ  <= dispE;
      modeQ  <= modeE;
      if (stb.finish) begin
        eaOut     <= eaCalc;
        regDirect <= info.direct;
        rmReg     <= modrmE[2:0];
        spareOut  <= modrmE[5:3];
        lenOut    <= stb.len;
      end
    end
  end
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode32,
  input  logic [BYTE_W-1:0]         inByte,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [REG_CNT*ADDR_W-1:0] regSnap,
  output logic [ADDR_W-1:0]         eaOut,
  output logic                      regDirect,
  output logic [2:0]                rmReg,
  output logic [2:0]                spareOut,
  output logic [LEN_W-1:0]          lenOut,
  output logic                      done
);
  strobe_t stb;

  ea_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode32 (mode32),
    .inByte (inByte),
    .inValid(inValid),
    .inReady(inReady),
    .done   (done),
    .stb    (stb)
  );

  ea_datapath dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode32   (mode32),
    .inByte   (inByte),
    .regSnap  (regSnap),
    .stb      (stb),
    .eaOut    (eaOut),
    .regDirect(regDirect),
    .rmReg    (rmReg),
    .spareOut (spareOut),
    .lenOut   (lenOut)
  );
endmodule

// File: rtl/ea_decoder_chk.sv
module ea_decoder_chk
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] eaOut,
  input logic              regDirect,
  input logic [LEN_W-1:0]  lenOut,
  input logic              done
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !inReady);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(inValid && inReady));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(eaOut) && $stable(lenOut) && $stable(regDirect)));

  assert_len_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lenOut != 3'd0 && lenOut != 3'd4 && lenOut <= 3'd6));

  assert_direct_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && regDirect) |-> (lenOut == 3'd1 && eaOut == '0));
endmodule

bind ea_decoder ea_decoder_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .eaOut    (eaOut),
  .regDirect(regDirect),
  .lenOut   (lenOut),
  .done     (done)
);

// File: tb/ea_decoder_tb.sv
module ea_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode32 = 1'b0;
  logic [7:0]   inByte = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [255:0] regSnap;
  logic [31:0]  eaOut;
  logic         regDirect;
  logic [2:0]   rmReg, spareOut, lenOut;
  logic         done;

  int errors = 0;
  int checks = 0;
  logic [31:0] rv [8];

  always #4 clk = ~clk;

  ea_decoder dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refModel(bit m32, logic [47:0] bv, output logic [31:0] ea,
                                   output int len, output bit direct);
    logic [1:0] md; logic [2:0] rm; logic [7:0] sb;
    logic [31:0] d, b, x; int dl, pos;
    md = bv[7:6]; rm = bv[2:0]; sb = bv[15:8];
    direct = 0; ea = 0; d = 0; b = 0; x = 0; pos = 1;
    if (md == 3) begin direct = 1; len = 1; return; end
    if (!m32) begin
      dl = (md == 1) ? 1 : (md == 2) ? 2 : (rm == 6) ? 2 : 0;
    end else begin
      if (rm == 4) pos = 2;
      dl = (md == 1) ? 1 : (md == 2) ? 4 :
           ((rm == 5) || (rm == 4 && sb[2:0] == 5)) ? 4 : 0;
    end
    for (int k = 0; k < dl; k++) d = d | (32'(bv[8*(pos+k) +: 8]) << (8*k));
    if (dl == 1) d = {{24{d[7]}}, d[7:0]};
    if (dl == 2) d = {{16{d[15]}}, d[15:0]};
    len = pos + dl;
    if (!m32) begin
      case (rm)
        0: begin b = rv[3]; x = rv[6]; end
        1: begin b = rv[3]; x = rv[7]; end
        2: begin b = rv[5]; x = rv[6]; end
        3: begin b = rv[5]; x = rv[7]; end
        4: b = rv[6];
        5: b = rv[7];
        6: b = (md == 0) ? 0 : rv[5];
        default: b = rv[3];
      endcase
      ea = {16'h0, b[15:0] + x[15:0] + d[15:0]};
    end else if (rm == 4) begin
      b = (md == 0 && sb[2:0] == 5) ? 0 : rv[sb[2:0]];
      x = (sb[5:3] == 4) ? 0 : (rv[sb[5:3]] << sb[7:6]);
      ea = b + x + d;
    end else begin
      b = (md == 0 && rm == 5) ? 0 : rv[rm];
      ea = b + d;
    end
  endfunction

  // drives n bytes (byte 0 in bits 7:0), with gap idle cycles before each later byte
  task automatic runSeq(string tag, bit m32, int n, logic [47:0] bv, int gap);
    logic [31:0] expEa; int expLen; bit expDir;
    refModel(m32, bv, expEa, expLen, expDir);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); inValid = 0;
        end
      end
      @(negedge clk);
      mode32 = m32; inValid = 1; inByte = bv[8*i +: 8];
      if (i > 0) check({tag, " R10 no early done"}, 32'(done), 32'd0);
    end
    @(negedge clk); inValid = 0;
    check({tag, " R10 done"}, 32'(done), 32'd1);
    check({tag, " R10 ready low"}, 32'(inReady), 32'd0);
    check({tag, " ea"}, eaOut, expEa);
    check({tag, " R1 len"}, 32'(lenOut), 32'(expLen));
    check({tag, " R2 direct"}, 32'(regDirect), 32'(expDir));
    check({tag, " R1 spare"}, 32'(spareOut), 32'(bv[5:3]));
    @(negedge clk);
    check({tag, " R10 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R10 hold"}, eaOut, expEa);
  endtask

  task automatic testReset();
    check("R11 done", 32'(done), 0);
    check("R11 ready", 32'(inReady), 1);
    check("R11 ea", eaOut, 0);
    check("R11 len", 32'(lenOut), 0);
    check("R11 direct/rm/spare", {26'h0, regDirect, rmReg, spareOut[1:0]}, 0);
  endtask

  task automatic testDirect();
    runSeq("R2 direct 32", 1, 1, 48'hD9, 0);
    check("R2 rm", 32'(rmReg), 1);
    runSeq("R2 direct 16", 0, 1, 48'hFE, 0);
    check("R2 rm16", 32'(rmReg), 6);
  endtask

  task automatic testSixteen();
    for (int r = 0; r < 8; r++)
      if (r != 6) runSeq("R3 mod0", 0, 1, 48'(r << 3 | r), 0);
    runSeq("R3 mod1 BP+DI neg", 0, 2, 48'h80_43, 0);
    runSeq("R3 mod2 BX+DI", 0, 3, 48'h1234_81, 0);
    runSeq("R3 mod1 BP", 0, 2, 48'h00_46, 0);
    runSeq("R4 disp16 only", 0, 3, 48'hF000_06, 0);
    runSeq("R9 wrap16", 0, 3, 48'h7FFF_87, 0);
    check("R9 upper zero", eaOut & 32'hFFFF0000, 0);
    runSeq("R9 neg disp16", 0, 3, 48'h8001_84, 0);
  endtask

  task automatic testThirtyTwo();
    runSeq("R5 EDI", 1, 1, 48'h07, 0);
    runSeq("R5 EBP-2", 1, 2, 48'hFE_45, 0);
    runSeq("R5 ECX+disp32", 1, 5, 48'h8765_4321_81, 0);
    runSeq("R6 disp32 only", 1, 5, 48'hDEAD_BEEF_05, 0);
  endtask

  task automatic testSib();
    runSeq("R7 EBX+ESI*4", 1, 2, 48'hB3_04, 0);
    runSeq("R7 scale1", 1, 2, 48'h08_04, 0);
    runSeq("R7 scale2", 1, 2, 48'h51_04, 0);
    runSeq("R7 no index", 1, 2, 48'hE3_04, 0);
    runSeq("R8 EDI*8+disp32", 1, 6, 48'h1000_0004_FD_04, 0);
    runSeq("R8 mod1 base EBP", 1, 3, 48'h10_2D_44, 0);
    runSeq("R9 sib disp32 wrap", 1, 6, 48'hFFFF_FFF0_00_84, 0);
  endtask

  task automatic testGaps();
    runSeq("R10 gaps 16", 0, 3, 48'h1234_81, 2);
    runSeq("R10 gaps sib", 1, 6, 48'h0000_0100_FD_04, 3);
  endtask

  task automatic testBackToBack();
    @(negedge clk); mode32 = 1; inValid = 1; inByte = 8'hC8;
    @(negedge clk); inByte = 8'hC1;
    check("R10 b2b done", 32'(done), 1);
    check("R10 b2b ready low", 32'(inReady), 0);
    check("R10 b2b rm first", 32'(rmReg), 0);
    @(negedge clk);
    check("R10 b2b not taken in done", 32'(done), 0);
    check("R10 b2b ready back", 32'(inReady), 1);
    @(negedge clk); inValid = 0;
    check("R10 b2b second done", 32'(done), 1);
    check("R10 b2b second rm", 32'(rmReg), 1);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rv[0] = 32'h0000_0100; rv[1] = 32'h0000_0200;
    rv[2] = 32'h0000_0300; rv[3] = 32'h1234_F000;
    rv[4] = 32'h0000_4000; rv[5] = 32'h8000_0010;
    rv[6] = 32'h0000_2222; rv[7] = 32'hFFFF_1001;
    for (int k = 0; k < 8; k++) regSnap[32*k +: 32] = rv[k];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testDirect();
    testSixteen();
    testThirtyTwo();
    testSib();
    testGaps();
    testBackToBack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule